// File: doc/BRIEF.md
# Unsigned Subtractor with Sign-Magnitude Output

This combinational block subtracts one unsigned operand from another and reports the difference as an unsigned magnitude with a separate sign flag. It does not return a wrapped two's-complement word. The subtrahend is inverted bit by bit and added to the minuend in a ripple adder, with the carry input held at 1. The carry out of the top cell, called the end carry, then decides how the sum is read.

When the end carry is set, the minuend was at least as large as the subtrahend. The carry is dropped and the low bits are taken as the answer. When the end carry is clear, the low bits hold the wrapped value 2^W − (n − m). The block negates that word to recover n − m and raises the sign flag.

Use the block wherever a downstream stage needs a distance and a direction instead of a signed word, for example in comparators or in magnitude-based steering logic. It has no clock. Its outputs follow its inputs after the delay of the adder and the negation.

Top module: `usub_signmag`

## Requirements
- R1: When m ≥ n, `mag` equals m − n and `neg` is 0.
- R2: When m < n, `mag` equals n − m, which is the two's complement of the wrapped sum, and `neg` is 1.
- R3: When m equals n, `mag` is 0 and `neg` is 0. The output pair `neg`=1 with `mag`=0 never occurs.
- R4: `neg` is 1 exactly when the end carry of m + ~n + 1 is 0, which is exactly when m < n.
- R5: With W=8, m=0x54 and n=0x43 give `mag`=0x11 and `neg`=0.
- R6: With W=8, m=0x43 and n=0x54 give `mag`=0x11 and `neg`=1. The intermediate wrapped sum for this pair is 0xEF.
- R7: At the extremes with W=8, m=0 and n=0xFF give `mag`=0xFF and `neg`=1, and m=0xFF and n=0 give `mag`=0xFF and `neg`=0.
- R8: The outputs depend only on the current inputs. After any input change they are settled within the same clock period of the bench, with no state kept from earlier operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| m | input | W | Minuend, unsigned |
| n | input | W | Subtrahend, unsigned |
| mag | output | W | Magnitude of m − n |
| neg | output | 1 | Set when m < n |

## Verification
The assertions are evaluated on every input change. They check the sign against the ordering of the operands (R4), the magnitude against the direct difference in both directions (R1, R2), the absence of negative zero (R3), the adder's sum against a whole-word addition, and the negation stage against an arithmetic negate. Only the bench shows the specific worked values and extreme operands (R5–R7). Only its exhaustive sweep shows that each new pair is settled within its own clock period, with nothing carried over from the previous pair (R8).

// File: rtl/usub_pkg.sv
package usub_pkg;
  localparam int unsigned USUB_DEFAULT_W = 8;

  // One-bit sum of a full adder: odd parity of the three inputs.
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // One-bit carry: generate, or propagate with an incoming carry.
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    logic gen;
    logic prop;
    gen  = a & b;
    prop = a ^ b;
    return gen | (prop & c);
  endfunction
endpackage

// File: rtl/usub_fa_cell.sv
module usub_fa_cell
  import usub_pkg::*;
(
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = fa_sum(a, b, ci);
    co = fa_carry(a, b, ci);
  end
endmodule

// File: rtl/usub_ripple_add.sv
module usub_ripple_add #(
  parameter int unsigned W = usub_pkg::USUB_DEFAULT_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int unsigned CW = W + 1;

  logic [CW-1:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_cell
    usub_fa_cell u_cell (
      .a  (a[i]),
      .b  (b[i]),
      .ci (chain[i]),
      .s  (sum[i]),
      .co (chain[i+1])
    );
  end

  assign cout = chain[W];

  // The ripple result must agree with a whole-word addition.
  logic [CW-1:0] wide_chk;
  always_comb begin
    wide_chk = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    AST_ADDER_SUM: assert ({cout, sum} == wide_chk) else $error("adder mismatch"); // R1
  end
endmodule

// File: rtl/usub_negate.sv
module usub_negate #(
  parameter int unsigned W = usub_pkg::USUB_DEFAULT_W
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  // Scan from the LSB: bits up to and including the first 1 pass through
  // unchanged, and every bit above that is inverted.
  logic [W:0] one_below;
  assign one_below[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i]           = x[i] ^ one_below[i];
    assign one_below[i+1] = one_below[i] | x[i];
  end

  logic [W-1:0] arith_neg;
  always_comb begin
    arith_neg = ~x + {{(W-1){1'b0}}, 1'b1};
    AST_NEGATE_MATCH: assert (y == arith_neg) else $error("negate mismatch"); // R2
  end
endmodule

// File: rtl/usub_signmag.sv
module usub_signmag #(
  parameter int unsigned W = usub_pkg::USUB_DEFAULT_W
) (
  input  logic [W-1:0] m,
  input  logic [W-1:0] n,
  output logic [W-1:0] mag,
  output logic         neg
);
  // Internal events brought out as named wires.
  logic [W-1:0] n_inv;
  logic [W-1:0] wrap_sum;
  logic         end_carry;
  logic [W-1:0] fixed_sum;

  assign n_inv = ~n;

  usub_ripple_add #(.W(W)) u_add (
    .a    (m),
    .b    (n_inv),
    .cin  (1'b1),
    .sum  (wrap_sum),
    .cout (end_carry)
  );

  usub_negate #(.W(W)) u_fix (
    .x (wrap_sum),
    .y (fixed_sum)
  );

  always_comb begin
    if (end_carry) begin
      mag = wrap_sum;
      neg = 1'b0;
    end else begin
      mag = fixed_sum;
      neg = 1'b1;
    end
  end

  logic [W-1:0] fwd_diff;
  logic [W-1:0] rev_diff;
  always_comb begin
    fwd_diff = m - n;
    rev_diff = n - m;
    AST_SIGN_ORDER:  assert (neg == (m < n)) else $error("sign vs order"); // R4
    AST_NO_NEG_ZERO: assert (!(neg && (mag == '0))) else $error("negative zero"); // R3
    AST_MAG_FWD:     assert (neg || (mag == fwd_diff)) else $error("fwd magnitude"); // R1
    AST_MAG_REV:     assert (!neg || (mag == rev_diff)) else $error("rev magnitude"); // R2
  end
endmodule

// File: tb/usub_signmag_test.sv
module usub_signmag_test;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] m = '0;
  logic [W-1:0] n = '0;
  logic [W-1:0] mag;
  logic         neg;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  int exp_mag_q[$];
  int exp_neg_q[$];

  usub_signmag #(.W(W)) uut (.m(m), .n(n), .mag(mag), .neg(neg));

  task automatic check(input string req, input int got_mag, input int got_neg,
                       input int want_mag, input int want_neg);
    tests++;
    if (got_mag != want_mag || got_neg != want_neg) begin
      fails++;
      $display("FAIL %s m=%0d n=%0d: mag=%0d neg=%0d expected mag=%0d neg=%0d",
               req, m, n, got_mag, got_neg, want_mag, want_neg);
    end
  endtask

  // Behavioural reference: signed integer difference split into sign and size.
  task automatic push_ref(input int a, input int b);
    int d;
    d = a - b;
    exp_neg_q.push_back(d < 0 ? 1 : 0);
    exp_mag_q.push_back(d < 0 ? -d : d);
  endtask

  task automatic apply(input int a, input int b, input string req);
    int wm;
    int wn;
    @(posedge clk);
    m = a[W-1:0];
    n = b[W-1:0];
    push_ref(a, b);
    @(negedge clk);
    wm = exp_mag_q.pop_front();
    wn = exp_neg_q.pop_front();
    check(req, int'(mag), int'(neg), wm, wn);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    // Zero inputs at start: equal operands give no negative zero (R3)
    @(negedge clk);
    check("R3", int'(mag), int'(neg), 0, 0);

    apply(8'h54, 8'h43, "R5");
    check("R5", int'(mag), int'(neg), 8'h11, 0);
    apply(8'h43, 8'h54, "R6");
    check("R6", int'(mag), int'(neg), 8'h11, 1);
    apply(0, 8'hFF, "R7");
    check("R7", int'(mag), int'(neg), 8'hFF, 1);
    apply(8'hFF, 0, "R7");
    check("R7", int'(mag), int'(neg), 8'hFF, 0);
    apply(8'h80, 8'h80, "R3");
    apply(8'hFF, 8'hFF, "R3");
    apply(1, 2, "R2");
    apply(2, 1, "R1");

    // Exhaustive sweep, one new pair every cycle (R1 R2 R4 R8)
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        if (a >= b) apply(a, b, "R1/R4/R8");
        else        apply(a, b, "R2/R4/R8");
      end
    end
    finish_run();
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end
endmodule